// File: doc/BRIEF.md
# Recovered-Clock Lock Supervisor with Loss-of-Signal Control

This block watches over a clock/data recovery loop. It measures the loop oscillator against a 19.44 MHz reference by counting oscillator edges across a fixed window of reference cycles. The count is compared with the value expected for the selected line rate: 622.08 MHz when `rateHi` is high and 155.52 MHz when it is low. A window counts as good when the count lies within a band of about 488 ppm. Two good windows in a row raise lock-detect, and one bad window clears it.

The signal-detect and lock-to-reference inputs can force the loop onto the reference. In that state the block raises a loss-of-signal flag, holds the retimed data output low and keeps lock-detect low. A test bypass routes the inverted reference to the clock output in place of the oscillator. The oscillator arrives as its own clock input. Its count reaches the reference domain through a toggle handshake.

Top module: `cdr_lock_top`

## Requirements
- R1: A synchronous active-low reset (`rstN` low at a `refClk` edge) leaves `lockDet` and `trackData` low on the next cycle.
- R2: `los` is high exactly when `bypass` is low and at least one of `sigDet` or `lockRefN` is low.
- R3: While `los` is high, `dataOut` is 0. Otherwise `dataOut` equals `dataIn`.
- R4: While `los` is high, `lockDet` and `trackData` are low in the same cycle. `trackData` (1 = loop tracks incoming data, 0 = loop tracks the reference) always equals `lockDet`.
- R5: A window is 4096 `refClk` cycles. The expected oscillator count is 4096×32 when `rateHi`=1 and 4096×8 when `rateHi`=0. A window is good when the absolute difference is at most the expected count shifted right by 11. The oscillator at a 200 ppm offset is accepted in low-rate mode. The oscillator at its low-rate frequency is rejected while `rateHi`=1.
- R6: `lockDet` rises only after two consecutive good windows. After a single good window it is still low.
- R7: One bad window (1000 ppm off) clears `lockDet` by the end of the window that follows.
- R8: Once `los` falls, `lockDet` needs two fresh good windows before it rises again.
- R9: When `bypass` and `rateHi` are both high, `clkOut` is the inverse of `refClk`. Otherwise `clkOut` is `oscClk`.
- R10: While `bypass` is high, `los` stays low whatever `sigDet` and `lockRefN` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock, 19.44 MHz nominal |
| oscClk | input | 1 | Loop oscillator clock being measured |
| rstN | input | 1 | Synchronous active-low reset, refClk domain |
| rateHi | input | 1 | 1 = 32× reference rate, 0 = 8× reference rate |
| sigDet | input | 1 | Signal present from the optical receiver, active high |
| lockRefN | input | 1 | Low forces the loop onto the reference |
| bypass | input | 1 | Test bypass of the loop |
| dataIn | input | 1 | Retimed data from the decision flop |
| clkOut | output | 1 | Selected output clock |
| dataOut | output | 1 | Gated retimed data |
| lockDet | output | 1 | Loop locked to data, outputs valid |
| los | output | 1 | Loss-of-signal flag |
| trackData | output | 1 | Loop select: 1 data, 0 reference |

## Verification
A wrong count in the oscillator domain, or a handshake that drops or repeats a window, shows as `lockDet` appearing one window early or late, or never appearing. That difference is visible within about two windows of a frequency step. A wrong good-window memory shows as lock one window too early after reset or after loss of signal clears. A fault in the forcing path appears at `lockDet`, `los` and `dataOut` in the very cycle the control inputs change.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;
  // Strobes from the control side to the measurement datapath
  typedef struct packed {
    logic winTick;   // last reference cycle of a measurement window
    logic hiRate;    // selects the 32x expected count
  } ctlStrobe_t;
endpackage

// File: rtl/cdr_freq_meter.sv
module cdr_freq_meter
  import cdr_lock_pkg::*;
#(
  parameter int unsigned WIN       = 4096,
  parameter int unsigned RATIO_HI  = 32,
  parameter int unsigned RATIO_LO  = 8,
  parameter int unsigned TOL_SHIFT = 11
) (
  input  logic       refClk,
  input  logic       oscClk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  output logic       measValid,
  output logic       inTol
);
  localparam int unsigned EXP_HI = WIN * RATIO_HI;
  localparam int unsigned EXP_LO = WIN * RATIO_LO;
  localparam int unsigned TOL_HI = EXP_HI >> TOL_SHIFT;
  localparam int unsigned TOL_LO = EXP_LO >> TOL_SHIFT;
  localparam int unsigned CNT_W  = $clog2(EXP_HI) + 2;

  // Reference domain: window boundary toggle
  logic winTgl;
  always_ff @(posedge refClk) begin
    if (!rstN)                winTgl <= 1'b0;
    else if (strobe.winTick)  winTgl <= ~winTgl;
  end

  // Oscillator domain: local reset sync, toggle sync, edge counter
  logic [1:0]       oscRstSync;
  logic             oscRstN;
  logic [2:0]       tglSync;
  logic             tglEdge;
  logic [CNT_W-1:0] oscCount;
  logic [CNT_W-1:0] holdCount;
  logic             ackTgl;

  always_ff @(posedge oscClk) oscRstSync <= {oscRstSync[0], rstN};
  assign oscRstN = oscRstSync[1];
  assign tglEdge = tglSync[2] ^ tglSync[1];

  always_ff @(posedge oscClk) begin
    if (!oscRstN) begin
      tglSync   <= '0;
      oscCount  <= '0;
      holdCount <= '0;
      ackTgl    <= 1'b0;
    end else begin
      tglSync <= {tglSync[1:0], winTgl};
      if (tglEdge) begin
        holdCount <= oscCount;
        oscCount  <= CNT_W'(1);
        ackTgl    <= ~ackTgl;
      end else begin
        oscCount  <= oscCount + CNT_W'(1);
      end
    end
  end

  // Reference domain: acknowledge sync and tolerance compare
  logic [2:0]       ackSync;
  logic             ackEdge;
  logic [CNT_W-1:0] expSel;
  logic [CNT_W-1:0] tolSel;
  logic [CNT_W-1:0] diff;

  assign ackEdge = ackSync[2] ^ ackSync[1];
  assign expSel  = strobe.hiRate ? CNT_W'(EXP_HI) : CNT_W'(EXP_LO);
  assign tolSel  = strobe.hiRate ? CNT_W'(TOL_HI) : CNT_W'(TOL_LO);
  assign diff    = (holdCount > expSel) ? (holdCount - expSel) : (expSel - holdCount);

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      ackSync   <= '0;
      measValid <= 1'b0;
      inTol     <= 1'b0;
    end else begin
      ackSync   <= {ackSync[1:0], ackTgl};
      measValid <= ackEdge;
      if (ackEdge) inTol <= (diff <= tolSel);
    end
  end

  // R5: captured count must be settled when the reference side reads it
  assert_hold_stable_R5: assert property (@(posedge refClk) disable iff (!rstN)
    ackEdge |-> $stable(holdCount));
endmodule

// File: rtl/cdr_lock_ctl.sv
module cdr_lock_ctl
  import cdr_lock_pkg::*;
#(
  parameter int unsigned WIN = 4096
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       rateHi,
  input  logic       sigDet,
  input  logic       lockRefN,
  input  logic       bypass,
  input  logic       measValid,
  input  logic       inTol,
  output ctlStrobe_t strobe,
  output logic       los,
  output logic       lockDet
);
  localparam int unsigned WIN_W = $clog2(WIN);

  logic [WIN_W-1:0] winCnt;
  logic             winTick;
  logic             oneGood;
  logic             lockReg;

  assign winTick = (winCnt == WIN_W'(WIN - 1));

  always_ff @(posedge refClk) begin
    if (!rstN)        winCnt <= '0;
    else if (winTick) winCnt <= '0;
    else              winCnt <= winCnt + WIN_W'(1);
  end

  assign strobe.winTick = winTick;
  assign strobe.hiRate  = rateHi;

  // Forced reference tracking
  assign los = ~bypass & (~sigDet | ~lockRefN);

  // Two good windows to lock, one bad window to unlock
  always_ff @(posedge refClk) begin
    if (!rstN) begin
      oneGood <= 1'b0;
      lockReg <= 1'b0;
    end else if (los) begin
      oneGood <= 1'b0;
      lockReg <= 1'b0;
    end else if (measValid) begin
      if (inTol) begin
        oneGood <= 1'b1;
        lockReg <= oneGood;
      end else begin
        oneGood <= 1'b0;
        lockReg <= 1'b0;
      end
    end
  end

  assign lockDet = lockReg & ~los;

  assert_lock_after_good_R6: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockReg) |-> $past(measValid && inTol));
  assert_drop_on_bad_R7: assert property (@(posedge refClk) disable iff (!rstN)
    (measValid && !inTol) |=> !lockReg);
  assert_los_clears_R8: assert property (@(posedge refClk) disable iff (!rstN)
    los |=> !lockReg);
endmodule

// File: rtl/cdr_lock_top.sv
module cdr_lock_top
  import cdr_lock_pkg::*;
#(
  parameter int unsigned WIN       = 4096,
  parameter int unsigned RATIO_HI  = 32,
  parameter int unsigned RATIO_LO  = 8,
  parameter int unsigned TOL_SHIFT = 11
) (
  input  logic refClk,
  input  logic oscClk,
  input  logic rstN,
  input  logic rateHi,
  input  logic sigDet,
  input  logic lockRefN,
  input  logic bypass,
  input  logic dataIn,
  output logic clkOut,
  output logic dataOut,
  output logic lockDet,
  output logic los,
  output logic trackData
);
  ctlStrobe_t strobe;
  logic       measValid;
  logic       inTol;

  cdr_lock_ctl #(.WIN(WIN)) u_ctl (
    .refClk(refClk), .rstN(rstN), .rateHi(rateHi), .sigDet(sigDet),
    .lockRefN(lockRefN), .bypass(bypass), .measValid(measValid), .inTol(inTol),
    .strobe(strobe), .los(los), .lockDet(lockDet)
  );

  cdr_freq_meter #(.WIN(WIN), .RATIO_HI(RATIO_HI), .RATIO_LO(RATIO_LO),
                   .TOL_SHIFT(TOL_SHIFT)) u_meter (
    .refClk(refClk), .oscClk(oscClk), .rstN(rstN), .strobe(strobe),
    .measValid(measValid), .inTol(inTol)
  );

  assign clkOut    = (bypass & rateHi) ? ~refClk : oscClk;
  assign dataOut   = dataIn & ~los;
  assign trackData = lockDet;

  assert_bypass_no_los_R10: assert property (@(posedge refClk) disable iff (!rstN)
    bypass |-> !los);
endmodule

// File: tb/sim_cdr_lock_top.sv
`timescale 1ns/1fs
module sim_cdr_lock_top;
  localparam int WIN = 4096;
  localparam real HALF_HI = 0.078125;
  localparam real HALF_LO = 0.3125;

  logic refClk = 1'b0, oscClk = 1'b0;
  logic rstN, rateHi, sigDet, lockRefN, bypass, dataIn;
  logic clkOut, dataOut, lockDet, los, trackData;
  real  oscHalf = HALF_HI;
  int   total = 0, bad = 0, cyc = 0;
  bit   finished = 1'b0;

  always #2.5 refClk = ~refClk;
  always #(oscHalf) oscClk = ~oscClk;
  always @(posedge refClk) cyc <= rstN ? cyc + 1 : 0;

  cdr_lock_top u0 (
    .refClk(refClk), .oscClk(oscClk), .rstN(rstN), .rateHi(rateHi), .sigDet(sigDet),
    .lockRefN(lockRefN), .bypass(bypass), .dataIn(dataIn), .clkOut(clkOut),
    .dataOut(dataOut), .lockDet(lockDet), .los(los), .trackData(trackData)
  );

  // {bypass, rateHi, sigDet, lockRefN, dataIn, expLos, expDataOut}
  localparam logic [6:0] VEC [8] = '{
    7'b0_1_1_1_1_0_1, 7'b0_1_0_1_1_1_0, 7'b0_1_1_0_1_1_0, 7'b0_0_0_0_1_1_0,
    7'b0_1_1_1_0_0_0, 7'b1_0_0_1_1_0_1, 7'b1_1_1_0_1_0_1, 7'b1_0_0_0_0_0_0
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic alignTo(input int phase);
    @(negedge refClk);
    while ((cyc % WIN) != phase) @(negedge refClk);
  endtask

  task automatic nextWin();
    repeat (WIN) @(negedge refClk);
  endtask

  task automatic doReset();
    @(negedge refClk); rstN = 1'b0;
    repeat (4) @(negedge refClk); rstN = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge refClk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; rateHi = 1'b1; sigDet = 1'b1; lockRefN = 1'b1; bypass = 1'b0; dataIn = 1'b0;
    repeat (4) @(negedge refClk); rstN = 1'b1;
    @(negedge refClk); #1;
    check(lockDet == 0, "R1 reset lockDet", lockDet, 0);
    check(trackData == 0, "R1 reset trackData", trackData, 0);

    // R9 clock selection while oscillator phase is aligned to the reference
    bypass = 1'b1; rateHi = 1'b1;
    @(negedge refClk); #0.03;
    check(clkOut == 1'b1, "R9 bypass low phase", clkOut, 1);
    @(posedge refClk); #0.03;
    check(clkOut == 1'b0, "R9 bypass high phase", clkOut, 0);
    rateHi = 1'b0;
    @(negedge refClk); #0.03;
    check(clkOut == oscClk, "R9 bypass lowrate osc", clkOut, oscClk);
    bypass = 1'b0; rateHi = 1'b1;
    @(negedge refClk); #0.03;
    check(clkOut == oscClk, "R9 normal osc", clkOut, oscClk);

    // R2 R3 R10 table
    for (int i = 0; i < 8; i++) begin
      @(negedge refClk);
      {bypass, rateHi, sigDet, lockRefN, dataIn} = VEC[i][6:2];
      #1;
      check(los == VEC[i][1], $sformatf("R2 R10 los vec%0d", i), los, VEC[i][1]);
      check(dataOut == VEC[i][0], $sformatf("R3 dataOut vec%0d", i), dataOut, VEC[i][0]);
    end
    @(negedge refClk);
    bypass = 1'b0; rateHi = 1'b1; sigDet = 1'b1; lockRefN = 1'b1; dataIn = 1'b1;

    // R6 lock after two good windows (high rate, 0 ppm)
    alignTo(50); nextWin(); #1;
    check(lockDet == 0, "R6 one window no lock", lockDet, 0);
    nextWin(); #1;
    check(lockDet == 1, "R6 lock after two", lockDet, 1);
    check(trackData == 1, "R4 trackData follows", trackData, 1);
    check(dataOut == 1, "R3 data passes", dataOut, 1);

    // R7 1000 ppm off
    oscHalf = HALF_HI * 1.001;
    nextWin(); #1;
    check(lockDet == 0, "R7 bad window drops", lockDet, 0);
    oscHalf = HALF_HI * 1.0001;
    nextWin(); #1;
    check(lockDet == 0, "R6 relock needs two", lockDet, 0);
    nextWin(); #1;
    check(lockDet == 1, "R5 100ppm accepted", lockDet, 1);

    // R4 R8 forced reference
    @(negedge refClk); sigDet = 1'b0; #1;
    check(lockDet == 0, "R4 los kills lock", lockDet, 0);
    check(trackData == 0, "R4 track reference", trackData, 0);
    check(dataOut == 0, "R3 data gated", dataOut, 0);
    alignTo(50); sigDet = 1'b1;
    nextWin(); #1;
    check(lockDet == 0, "R8 one window after los", lockDet, 0);
    nextWin(); #1;
    check(lockDet == 1, "R8 relock after los", lockDet, 1);
    @(negedge refClk); lockRefN = 1'b0; #1;
    check(lockDet == 0, "R4 lockRefN forces", lockDet, 0);
    @(negedge refClk); lockRefN = 1'b1; #1;
    check(lockDet == 0, "R8 no instant relock", lockDet, 0);

    // R1 R5 low rate
    rateHi = 1'b0; oscHalf = HALF_LO * 1.0002;
    doReset(); #1;
    check(lockDet == 0, "R1 reset clears", lockDet, 0);
    alignTo(50); nextWin(); nextWin(); #1;
    check(lockDet == 1, "R5 low rate lock", lockDet, 1);
    rateHi = 1'b1;
    nextWin(); nextWin(); #1;
    check(lockDet == 0, "R5 wrong rate rejected", lockDet, 0);
    @(negedge refClk); doReset(); @(negedge refClk); #1;
    check(lockDet == 0 && trackData == 0, "R1 final reset", lockDet, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule